// File: doc/BRIEF.md
# Sequential Keypad Combination Lock

This block is a four-digit combination lock that watches a bank of keypad lines, with one line for each key. Four of the keys are assigned by parameter to code positions one to four. Every other key counts as a wrong key. The lock is built as a chain of four one-bit stages. A press of code key n loads stage n from stage n-1, and the first stage loads a constant 1. The unlock output is the last stage. It therefore goes high only when the four code keys have been pressed in order.

A press on any wrong key empties the whole chain at once. An optional timeout also empties the chain after unlock has been held for a programmed number of clock cycles. The key lines arrive already debounced but asynchronous. They are brought onto the system clock through two flip-flops and then edge-detected, so every stage update is synchronous. Matrix scanning, debouncing and actuator drive are handled elsewhere.

Top module: `keychain_lock`

## Requirements
- R1: While rst_n is low at a rising clock edge, all four stages, unlock_o and the timeout counter are cleared to 0.
- R2: A press is the low-to-high transition of a key line. A key first sampled high at clock edge k affects the stages at edge k+2. Holding a key high after that has no further effect.
- R3: A press of code key 1 (line index CODE0, default 3) sets stage_o[0] to 1.
- R4: A press of code key n, for n = 2..4 (line indices CODE1, CODE2, CODE3, defaults 7, 1, 9), loads stage_o[n-1] with the value stage_o[n-2] held before that edge.
- R5: A code key pressed out of order, while the stage before it is clear, loads 0 into its stage. The sequence must then be restarted from the first digit.
- R6: A press on any line that is not one of the four code lines clears all four stages at the same edge.
- R7: unlock_o equals stage_o[3]. Once set, it stays high until a wrong key or the timeout clears the chain.
- R8: If a code-key press and a wrong-key press are detected in the same cycle, all stages clear and the code press is discarded.
- R9: With timeout_i = T > 0, unlock_o stays high for exactly T clock cycles and then all stages clear. With T = 0, no automatic clear happens.
- R10: Pressing a code key again while its stage is set and the stage before it is still set leaves the chain unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| keys_i | input | NUM_KEYS | Debounced key lines, one per key, high while pressed |
| timeout_i | input | TMO_W | Unlock hold time in clock cycles; 0 disables the timeout |
| unlock_o | output | 1 | High while the full code has been accepted |
| stage_o | output | 4 | Stage states; bit 0 is the first digit, bit 3 the last |

## Verification
Two clearing paths can meet a code-key load in the same cycle. One is a wrong key arriving on the same edge as a code key. The other is the timeout expiring just as a code key is pressed while the lock is open. The bench raises a wrong key line and a code key line on the same clock edge, and separately presses the final code key again while the timeout is close to expiry. It judges each case against a cycle-level reference model in which any clear takes precedence over every load.

// File: rtl/lock_pkg.sv
// lock_pkg: shared constants and types for the keypad combination lock.
// Assumes a fixed code length of four positions.
package lock_pkg;
    localparam int unsigned STAGES = 4;
    typedef logic [STAGES-1:0] stage_vec_t;
endpackage

// File: rtl/key_edge.sv
// key_edge: brings asynchronous, already-debounced key lines onto clk
// through a two-flop synchroniser and flags each low-to-high transition
// for one cycle. Assumes lines are held stable for several clock cycles.
module key_edge #(
    parameter int unsigned NUM_KEYS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] keys_i,
    output logic [NUM_KEYS-1:0] rise_o
);
    logic [NUM_KEYS-1:0] meta_q;
    logic [NUM_KEYS-1:0] sync_q;
    logic [NUM_KEYS-1:0] last_q;

    for (genvar g = 0; g < NUM_KEYS; g++) begin : g_line
        // Synchronise one key line and keep its previous synchronised level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[g] <= 1'b0;
                sync_q[g] <= 1'b0;
                last_q[g] <= 1'b0;
            end else begin
                meta_q[g] <= keys_i[g];
                sync_q[g] <= meta_q[g];
                last_q[g] <= sync_q[g];
            end
        end

        // Flag a rise when the synchronised level is new this cycle.
        assign rise_o[g] = sync_q[g] & ~last_q[g];
    end
endmodule

// File: rtl/key_decode.sv
// key_decode: sorts key rises into the four code-position presses and a
// single wrong-key flag. Assumes the four code indices are distinct and
// lie below NUM_KEYS.
module key_decode
    import lock_pkg::*;
#(
    parameter int unsigned NUM_KEYS = 16,
    parameter int unsigned CODE0    = 3,
    parameter int unsigned CODE1    = 7,
    parameter int unsigned CODE2    = 1,
    parameter int unsigned CODE3    = 9
) (
    input  logic [NUM_KEYS-1:0] rise_i,
    output stage_vec_t          press_o,
    output logic                wrong_o
);
    localparam logic [NUM_KEYS-1:0] ONE = NUM_KEYS'(1);
    localparam logic [NUM_KEYS-1:0] CODE_MASK =
        (ONE << CODE0) | (ONE << CODE1) | (ONE << CODE2) | (ONE << CODE3);

    // Route each code line's rise to its chain position.
    always_comb begin
        press_o[0] = rise_i[CODE0];
        press_o[1] = rise_i[CODE1];
        press_o[2] = rise_i[CODE2];
        press_o[3] = rise_i[CODE3];
    end

    // Any rise outside the code set is a wrong key.
    assign wrong_o = |(rise_i & ~CODE_MASK);
endmodule

// File: rtl/lock_chain.sv
// lock_chain: four one-bit stages. A press loads stage 0 with 1 and
// stage n with stage n-1. A clear empties all stages and beats any load.
module lock_chain
    import lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  stage_vec_t press_i,
    input  logic       clear_i,
    output stage_vec_t stage_o
);
    stage_vec_t stage_q;
    stage_vec_t load_val;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign load_val[g] = 1'b1;
        end else begin : g_next
            assign load_val[g] = stage_q[g-1];
        end

        // Update one stage: clear first, then its own press.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[g] <= 1'b0;
            end else if (clear_i) begin
                stage_q[g] <= 1'b0;
            end else if (press_i[g]) begin
                stage_q[g] <= load_val[g];
            end
        end
    end

    assign stage_o = stage_q;
endmodule

// File: rtl/unlock_timer.sv
// unlock_timer: counts cycles with unlock high and raises expire_o in the
// cycle where the count reaches timeout_i, so that unlock lasts exactly
// timeout_i cycles. A timeout of 0 never expires.
module unlock_timer #(
    parameter int unsigned TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unlock_i,
    input  logic [TMO_W-1:0] timeout_i,
    output logic             expire_o
);
    logic [TMO_W-1:0] cnt_q;

    assign expire_o = unlock_i && (timeout_i != '0) &&
                      (cnt_q == timeout_i - TMO_W'(1));

    // Count open cycles; restart whenever the lock is closed or expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!unlock_i || expire_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + TMO_W'(1);
        end
    end
endmodule

// File: rtl/keychain_lock.sv
// keychain_lock: four-digit sequential combination lock. Key rises load
// a chain of stages; a wrong key or timeout empties it. Assumes debounced
// key lines and a synchronous active-low reset.
module keychain_lock
    import lock_pkg::*;
#(
    parameter int unsigned NUM_KEYS = 16,
    parameter int unsigned CODE0    = 3,
    parameter int unsigned CODE1    = 7,
    parameter int unsigned CODE2    = 1,
    parameter int unsigned CODE3    = 9,
    parameter int unsigned TMO_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] keys_i,
    input  logic [TMO_W-1:0]    timeout_i,
    output logic                unlock_o,
    output logic [STAGES-1:0]   stage_o
);
    logic [NUM_KEYS-1:0] rise_w;
    stage_vec_t          press_w;
    logic                wrong_w;
    logic                expire_w;
    logic                clear_w;
    stage_vec_t          stage_w;

    key_edge #(.NUM_KEYS(NUM_KEYS)) u_edge (
        .clk(clk), .rst_n(rst_n), .keys_i(keys_i), .rise_o(rise_w)
    );

    key_decode #(
        .NUM_KEYS(NUM_KEYS), .CODE0(CODE0), .CODE1(CODE1),
        .CODE2(CODE2), .CODE3(CODE3)
    ) u_dec (
        .rise_i(rise_w), .press_o(press_w), .wrong_o(wrong_w)
    );

    // Either clearing source empties the chain.
    assign clear_w = wrong_w | expire_w;

    lock_chain u_chain (
        .clk(clk), .rst_n(rst_n), .press_i(press_w),
        .clear_i(clear_w), .stage_o(stage_w)
    );

    unlock_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .unlock_i(stage_w[STAGES-1]),
        .timeout_i(timeout_i), .expire_o(expire_w)
    );

    assign stage_o  = stage_w;
    assign unlock_o = stage_w[STAGES-1];
endmodule

// File: rtl/lock_checker.sv
// lock_checker: temporal properties of keychain_lock, bound to the top.
module lock_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] press,
    input logic       wrong,
    input logic       tmo_clr,
    input logic [3:0] stage,
    input logic       unlock
);
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (stage == 4'b0000));

    p_quiet_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (press == 4'b0000) && !wrong && !tmo_clr |=> $stable(stage));

    p_first_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        press[0] && !wrong && !tmo_clr |=> stage[0]);

    p_chain_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        press[2] && !wrong && !tmo_clr |=> (stage[2] == $past(stage[1])));

    p_wrong_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrong |=> (stage == 4'b0000));

    p_unlock_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        unlock && !wrong && !tmo_clr |=> unlock);

    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wrong && (press != 4'b0000) |=> (stage == 4'b0000));

    p_timeout_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_clr |=> !unlock);
endmodule

bind keychain_lock lock_checker u_chk (
    .clk(clk), .rst_n(rst_n), .press(press_w), .wrong(wrong_w),
    .tmo_clr(expire_w), .stage(stage_o), .unlock(unlock_o)
);

// File: tb/keychain_lock_test.sv
module keychain_lock_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NK = 16;
    localparam int  K1 = 3, K2 = 7, K3 = 1, K4 = 9;
    localparam int  BAD_A = 0, BAD_B = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NK-1:0] keys = '0;
    logic [15:0]   tmo = '0;
    logic          unlock_o;
    logic [3:0]    stage_o;

    int    n_chk = 0, n_fail = 0, cyc = 0;
    bit    armed = 0;
    string phase = "R1";

    // Reference model state.
    logic [NK-1:0] hist [3];
    logic [3:0]    m_st;
    int            m_open;

    keychain_lock uut (
        .clk(clk), .rst_n(rst_n), .keys_i(keys), .timeout_i(tmo),
        .unlock_o(unlock_o), .stage_o(stage_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Behavioural model: a press is seen two samples after the line rises.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) hist[i] = '0;
            m_st = 4'b0; m_open = 0;
        end else begin
            logic [NK-1:0] r;
            logic [3:0]    old;
            bit            bad, expd;
            int            codes [4];
            codes = '{K1, K2, K3, K4};
            r = hist[1] & ~hist[2];
            bad = 0;
            for (int i = 0; i < NK; i++)
                if (r[i] && i != K1 && i != K2 && i != K3 && i != K4) bad = 1;
            expd = m_st[3] && tmo != 0 && (m_open + 1 == int'(tmo));
            old = m_st;
            if (bad || expd) m_st = 4'b0;
            else for (int n = 0; n < 4; n++)
                if (r[codes[n]]) m_st[n] = (n == 0) ? 1'b1 : old[n-1];
            m_open = (m_st[3] && old[3] && !expd) ? m_open + 1 : 0;
            hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = keys;
        end
        armed = 1;
    end

    // Compare against the model every cycle, away from the active edge.
    always @(negedge clk) if (armed) begin
        check(stage_o === m_st, phase, stage_o, m_st);
        check(unlock_o === m_st[3], "R7", unlock_o, m_st[3]);
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input int k);
        @(negedge clk); keys[k] = 1'b1;
        tick(5);
        keys[k] = 1'b0;
        tick(4);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; keys = '0;
        tick(3); rst_n = 1'b1; tick(2);
    endtask

    initial begin
        tick(3);
        check(stage_o == 4'b0 && unlock_o == 1'b0, "R1", {unlock_o, stage_o}, 0);
        rst_n = 1'b1; tick(2);

        // R2: latency and level insensitivity of a press.
        phase = "R2";
        @(negedge clk); keys[K1] = 1'b1;
        tick(1); check(stage_o[0] == 1'b0, "R2", stage_o, 0);
        tick(1); check(stage_o[0] == 1'b0, "R2", stage_o, 0);
        tick(1); check(stage_o[0] == 1'b1, "R3", stage_o, 1);
        tick(20); keys[K1] = 1'b0; tick(4);
        check(stage_o == 4'b0001, "R2", stage_o, 1);

        // R4/R7: the full code opens the lock and it stays open.
        phase = "R4";
        press(K2); press(K3);
        check(stage_o == 4'b0111, "R4", stage_o, 4'h7);
        press(K4);
        check(unlock_o == 1'b1 && stage_o == 4'hF, "R7", {unlock_o, stage_o}, 5'h1F);
        phase = "R9"; tick(60);
        check(unlock_o == 1'b1, "R9", unlock_o, 1);

        // R10: repeating a code key while its predecessor is set.
        phase = "R10";
        press(K4); press(K2);
        check(stage_o == 4'hF, "R10", stage_o, 4'hF);

        // R6: a wrong key empties the chain.
        phase = "R6";
        press(BAD_A);
        check(stage_o == 4'h0 && unlock_o == 1'b0, "R6", stage_o, 0);

        // R5: out-of-order entry.
        phase = "R5";
        press(K2); press(K1); press(K3);
        check(stage_o == 4'b0001, "R5", stage_o, 1);
        press(K4);
        check(unlock_o == 1'b0, "R5", unlock_o, 0);

        // R8: code and wrong key rise on the same edge.
        phase = "R8";
        @(negedge clk); keys[K2] = 1'b1; keys[BAD_B] = 1'b1;
        tick(5); keys = '0; tick(4);
        check(stage_o == 4'h0, "R8", stage_o, 0);

        // R9: timed unlock lasts exactly T cycles.
        phase = "R9";
        do_reset();
        tmo = 16'd5;
        press(K1); press(K2); press(K3);
        begin
            int open = 0;
            @(negedge clk); keys[K4] = 1'b1;
            for (int i = 0; i < 40; i++) begin
                tick(1);
                if (unlock_o) open++;
            end
            keys[K4] = 1'b0;
            check(open == 5, "R9", open, 5);
        end
        check(stage_o == 4'h0, "R9", stage_o, 0);

        // R9 and R10 meeting: re-press last key near expiry.
        press(K1); press(K2); press(K3);
        @(negedge clk); keys[K4] = 1'b1; tick(3);
        keys[K4] = 1'b0; keys[K4] = 1'b0;
        @(negedge clk); keys[K4] = 1'b0; tick(1); keys[K4] = 1'b1;
        tick(12); keys[K4] = 1'b0; tick(4);
        check(unlock_o == 1'b0, "R9", unlock_o, 0);

        // R1: reset in the middle of a sequence.
        tmo = '0;
        press(K1); press(K2);
        phase = "R1";
        do_reset();
        check(stage_o == 4'h0, "R1", stage_o, 0);

        tick(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule